// File: doc/BRIEF.md
# Packet Error Check CRC-8 Unit

This block keeps a running CRC-8 over the bytes of a two-wire management bus transaction and turns it into the packet error check byte. Every byte that crosses the bus is fed to it: the address byte with its write bit, the command, the address byte sent again after a repeated start with its read bit, and the data bytes. One byte is taken per clock, marked by a valid strobe. A clear input opens a new transaction.

The byte that closes a transaction carries a last marker. The mode input sets what happens with that byte. In transmit mode the last byte is the final data byte. One cycle later the running value on `crc_o` is the check byte to append, and a done pulse announces it. In receive mode the last byte is the check byte received from the far end. The unit folds it into the running value and then reports a good or a bad packet. A packet is good when the residue is zero. The command layer uses that verdict to decide whether to act on the command.

The CRC uses the generator x^8 + x^2 + x + 1 (0x07). The register starts at 0x00 and takes each byte most significant bit first. Nothing is reflected and there is no output XOR.

Top module: `pec_crc8_unit`

## Requirements
- R1: After reset `crc_o` is 0x00 and `tx_done_o`, `pec_ok_o` and `pec_bad_o` are all 0.
- R2: When `byte_vld_i` is 1 without `clr_i`, `crc_o` in the next cycle equals the CRC-8 step of the previous `crc_o` with `byte_i`. The step uses generator 0x07, takes the byte MSB first, has no reflection and no final XOR. From 0x00, the byte 0x01 gives 0x07, and the ASCII string "123456789" gives 0xF4.
- R3: In a cycle with neither `byte_vld_i` nor `clr_i`, `crc_o` keeps its value into the next cycle.
- R4: `clr_i` without `byte_vld_i` sets `crc_o` to 0x00 in the next cycle and discards whatever had been accumulated.
- R5: `clr_i` together with `byte_vld_i` restarts the accumulation with that byte. The next `crc_o` is the step of 0x00 with `byte_i`.
- R6: A valid byte with `last_i`=1 and `rx_mode_i`=0 gives a one-cycle `tx_done_o` pulse in the next cycle. In that same cycle `crc_o` holds the check byte over all bytes fed so far.
- R7: A valid byte with `last_i`=1 and `rx_mode_i`=1 gives a one-cycle pulse in the next cycle. The pulse is on `pec_ok_o` if the CRC over all bytes, the received check byte included, is 0x00. Otherwise it is on `pec_bad_o`.
- R8: Address bytes count as ordinary bytes. The address resent after a repeated start, with its read bit, goes into the same running CRC without a clear. A read transaction whose check byte covers both address bytes is therefore reported good.
- R9: `tx_done_o`, `pec_ok_o` and `pec_bad_o` are 0 in every cycle that does not follow a valid last byte, and at most one of them is 1 at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Start of transaction: discard the running CRC |
| byte_vld_i | input | 1 | `byte_i` holds a bus byte this cycle |
| byte_i | input | 8 | Bus byte (address, command, data or check byte) |
| last_i | input | 1 | With `byte_vld_i`: this byte ends the transaction |
| rx_mode_i | input | 1 | 0: transmit (produce the check byte), 1: receive (verify it) |
| crc_o | output | 8 | Running CRC; the check byte after a transmit last byte |
| tx_done_o | output | 1 | One-cycle pulse: `crc_o` is the check byte to append |
| pec_ok_o | output | 1 | One-cycle pulse: received packet verified |
| pec_bad_o | output | 1 | One-cycle pulse: received packet failed the check |

## Verification
Every result is due exactly one clock after the edge that samples its byte. That covers the new `crc_o` and the transmit done pulse, as well as the good and bad verdicts. The bench drives inputs on the falling edge and computes, before that rising edge, what the outputs must show after it. It compares at the next falling edge, so each check lands on the one cycle in which its result is defined. Because every cycle is compared, a flag that comes a cycle early or late, or lasts a cycle too long, is seen as a mismatch in a neighbouring cycle.

// File: rtl/pec_crc8_pkg.sv
package pec_crc8_pkg;

  localparam int BYTE_W = 8;

  typedef logic [BYTE_W-1:0] byte_t;

  // One byte through the CRC register, MSB first, fully unrolled.
  function automatic byte_t crc8_step(input byte_t cur, input byte_t din, input byte_t poly);
    byte_t r;
    r = cur ^ din;
    for (int k = 0; k < BYTE_W; k++) begin
      if (r[BYTE_W-1]) r = (r << 1) ^ poly;
      else             r = r << 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/pec_crc8_accum.sv
module pec_crc8_accum
  import pec_crc8_pkg::*;
#(
  parameter byte_t POLY = 8'h07
) (
  input  logic  clk,
  input  logic  rst_n,
  input  logic  clr,
  input  logic  vld,
  input  byte_t data,
  output byte_t crc_q,
  output byte_t step_o
);

  byte_t base;

  // A clear in the same cycle as a byte restarts from zero.
  always_comb begin
    base   = clr ? '0 : crc_q;
    step_o = crc8_step(base, data, POLY);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= '0;
    else if (vld) crc_q <= step_o;
    else if (clr) crc_q <= '0;
  end

endmodule

// File: rtl/pec_crc8_verdict.sv
module pec_crc8_verdict (
  input  logic clk,
  input  logic rst_n,
  input  logic fin,
  input  logic rx,
  input  logic resid_zero,
  output logic tx_done,
  output logic ok,
  output logic bad
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_done <= 1'b0;
      ok      <= 1'b0;
      bad     <= 1'b0;
    end else begin
      tx_done <= fin && !rx;
      ok      <= fin && rx && resid_zero;
      bad     <= fin && rx && !resid_zero;
    end
  end

endmodule

// File: rtl/pec_crc8_unit.sv
module pec_crc8_unit
  import pec_crc8_pkg::*;
#(
  parameter byte_t POLY = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       byte_vld_i,
  input  logic [7:0] byte_i,
  input  logic       last_i,
  input  logic       rx_mode_i,
  output logic [7:0] crc_o,
  output logic       tx_done_o,
  output logic       pec_ok_o,
  output logic       pec_bad_o
);

  // Named internal events, visible to the bound checker.
  byte_t step_crc;
  logic  fin_evt;
  logic  step_zero;

  assign fin_evt   = byte_vld_i && last_i;
  assign step_zero = (step_crc == '0);

  pec_crc8_accum #(.POLY(POLY)) i_accum (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (clr_i),
    .vld    (byte_vld_i),
    .data   (byte_i),
    .crc_q  (crc_o),
    .step_o (step_crc)
  );

  pec_crc8_verdict i_verdict (
    .clk        (clk),
    .rst_n      (rst_n),
    .fin        (fin_evt),
    .rx         (rx_mode_i),
    .resid_zero (step_zero),
    .tx_done    (tx_done_o),
    .ok         (pec_ok_o),
    .bad        (pec_bad_o)
  );

endmodule

// File: rtl/pec_crc8_unit_chk.sv
module pec_crc8_unit_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       clr_i,
  input logic       byte_vld_i,
  input logic       last_i,
  input logic       rx_mode_i,
  input logic [7:0] crc_o,
  input logic [7:0] step_crc,
  input logic       tx_done_o,
  input logic       pec_ok_o,
  input logic       pec_bad_o
);

  a_r2_step_lands: assert property (@(posedge clk) disable iff (!rst_n)
    byte_vld_i |=> (crc_o == $past(step_crc)));

  a_r3_idle_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !byte_vld_i) |=> $stable(crc_o));

  a_r4_clear_discards: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !byte_vld_i) |=> (crc_o == 8'h00));

  a_r6_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done_o |-> $past(byte_vld_i && last_i && !rx_mode_i));

  a_r7_ok_zero_residue: assert property (@(posedge clk) disable iff (!rst_n)
    pec_ok_o |-> (crc_o == 8'h00));

  a_r7_bad_nonzero_residue: assert property (@(posedge clk) disable iff (!rst_n)
    pec_bad_o |-> (crc_o != 8'h00));

  a_r9_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_done_o, pec_ok_o, pec_bad_o}));

  a_r9_verdict_after_rx_last: assert property (@(posedge clk) disable iff (!rst_n)
    (pec_ok_o || pec_bad_o) |-> $past(byte_vld_i && last_i && rx_mode_i));

endmodule

bind pec_crc8_unit pec_crc8_unit_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .clr_i      (clr_i),
  .byte_vld_i (byte_vld_i),
  .last_i     (last_i),
  .rx_mode_i  (rx_mode_i),
  .crc_o      (crc_o),
  .step_crc   (step_crc),
  .tx_done_o  (tx_done_o),
  .pec_ok_o   (pec_ok_o),
  .pec_bad_o  (pec_bad_o)
);

// File: tb/test_pec_crc8_unit.sv
`timescale 1ns/1ps
module test_pec_crc8_unit;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clr_i = 1'b0;
  logic       byte_vld_i = 1'b0;
  logic [7:0] byte_i = 8'h00;
  logic       last_i = 1'b0;
  logic       rx_mode_i = 1'b0;
  logic [7:0] crc_o;
  logic       tx_done_o, pec_ok_o, pec_bad_o;

  int total = 0;
  int bad = 0;
  logic [7:0] m_crc = 8'h00;

  always #2 clk = ~clk;

  pec_crc8_unit i_pec_crc8_unit (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .byte_vld_i(byte_vld_i),
    .byte_i(byte_i), .last_i(last_i), .rx_mode_i(rx_mode_i),
    .crc_o(crc_o), .tx_done_o(tx_done_o), .pec_ok_o(pec_ok_o), .pec_bad_o(pec_bad_o)
  );

  // Bit-serial long division, written independently of the design.
  function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c;
    for (int i = 7; i >= 0; i--) begin
      logic fb;
      fb = r[7] ^ d[i];
      r  = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  task automatic check(input string tag, input string what, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, got, exp);
    end
  endtask

  // Drive one cycle at the falling edge, predict, compare at the next falling edge.
  task automatic step(input logic c, input logic v, input logic [7:0] b,
                      input logic l, input logic r, input string tag);
    logic [7:0] nxt;
    logic [2:0] eflg;
    clr_i = c; byte_vld_i = v; byte_i = b; last_i = l; rx_mode_i = r;
    if (v)      nxt = ref_crc(c ? 8'h00 : m_crc, b);
    else if (c) nxt = 8'h00;
    else        nxt = m_crc;
    eflg = {v && l && !r, v && l && r && (nxt == 8'h00), v && l && r && (nxt != 8'h00)};
    @(posedge clk);
    @(negedge clk);
    m_crc = nxt;
    check(tag, "crc_o", int'(crc_o), int'(nxt));
    check((v && l) ? tag : "R9", "flags{done,ok,bad}",
          int'({tx_done_o, pec_ok_o, pec_bad_o}), int'(eflg));
  endtask

  task automatic idle(input string tag);
    step(1'b0, 1'b0, 8'h00, 1'b0, 1'b0, tag);
  endtask

  initial begin
    #800000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [7:0] pec;
    @(negedge clk); @(negedge clk);
    // R1: reset state
    check("R1", "crc_o", int'(crc_o), 0);
    check("R1", "flags", int'({tx_done_o, pec_ok_o, pec_bad_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    idle("R3");

    // R2: single byte and the standard check string
    step(1'b1, 1'b1, 8'h01, 1'b0, 1'b0, "R5");
    check("R2", "crc of 0x01", int'(crc_o), 8'h07);
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R4");
    for (int i = 0; i < 9; i++) step(1'b0, 1'b1, 8'h31 + 8'(i), 1'b0, 1'b0, "R2");
    check("R2", "crc of 123456789", int'(crc_o), 8'hF4);

    // R3: idle cycles keep the value
    for (int i = 0; i < 3; i++) idle("R3");
    check("R3", "held value", int'(crc_o), 8'hF4);

    // R4: clear in mid transaction
    step(1'b0, 1'b1, 8'hA5, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b0, 8'h00, 1'b0, 1'b0, "R4");
    check("R4", "cleared", int'(crc_o), 0);

    // R5: clear together with a byte restarts from that byte
    step(1'b0, 1'b1, 8'h3C, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 8'h01, 1'b0, 1'b0, "R5");
    check("R5", "restart with byte", int'(crc_o), 8'h07);

    // R6: write transaction, check byte produced after last data byte
    step(1'b1, 1'b1, 8'hB4, 1'b0, 1'b0, "R8");
    step(1'b0, 1'b1, 8'h21, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, 8'h9A, 1'b0, 1'b0, "R2");
    step(1'b0, 1'b1, 8'h0C, 1'b1, 1'b0, "R6");
    check("R6", "tx_done pulse", int'(tx_done_o), 1);
    idle("R6");
    check("R6", "tx_done one cycle", int'(tx_done_o), 0);

    // R7, R8: read with repeated start, correct check byte
    step(1'b1, 1'b1, 8'hB4, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h8B, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'hB5, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h5E, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h02, 1'b0, 1'b1, "R8");
    pec = m_crc;
    idle("R3");
    step(1'b0, 1'b1, pec, 1'b1, 1'b1, "R7");
    check("R8", "good read verdict", int'(pec_ok_o), 1);
    idle("R9");

    // R7: same read with a corrupted check byte
    step(1'b1, 1'b1, 8'hB4, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h8B, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'hB5, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h5E, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h02, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, pec ^ 8'h10, 1'b1, 1'b1, "R7");
    check("R7", "bad verdict", int'(pec_bad_o), 1);
    idle("R9");

    // R8: dropping the repeated address breaks the check
    step(1'b1, 1'b1, 8'hB4, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h8B, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h5E, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, 8'h02, 1'b0, 1'b1, "R8");
    step(1'b0, 1'b1, pec, 1'b1, 1'b1, "R8");
    idle("R9");

    // R9: back-to-back last bytes in both modes
    step(1'b1, 1'b1, 8'h00, 1'b1, 1'b1, "R7");
    step(1'b0, 1'b1, 8'h77, 1'b1, 1'b0, "R6");
    step(1'b0, 1'b1, 8'h12, 1'b1, 1'b1, "R7");
    idle("R9");
    idle("R9");

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule